// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into characters. It oversamples the line with a 16x enable pulse from an external rate generator. It checks each start bit at its middle and then samples every data, parity and stop bit at its middle. The character size is 5 to 8 bits, sent least significant bit first, and a parity bit is optional. Each finished character goes into a three-entry queue. The break, framing-error and parity-error flags go into the same entry as the data, so a flag always describes the character stored beside it.

The host drives the configuration fields and a small command port directly. It reads the character at the head of the queue and pops it with a one-cycle pulse. It also watches a status byte and an interrupt request. A mode input selects how errors appear in the status byte. In one setting they follow the head character. In the other they build up until the host clears them explicitly.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_bits` sets the number of data bits (00 = 5, 01 = 6, 10 = 7, 11 = 8). Bits arrive least significant first. `rd_data` shows them zero-extended to 8 bits.
- R2: A start bit counts only if the line is still low 8 ticks after the first low tick. A low pulse shorter than half a bit loads nothing.
- R3: With `cfg_par_mode` = 00 a parity bit follows the data. It is checked for even (`cfg_par_odd` = 0) or odd (`cfg_par_odd` = 1) parity over data plus parity bit, and a mismatch sets the parity tag.
- R4: With `cfg_par_mode` = 01 the parity bit must equal `cfg_par_odd`, and any other value sets the parity tag. With `cfg_par_mode` = 10 the frame has no parity bit.
- R5: With `cfg_par_mode` = 11 the parity-position bit is stored as the character's address flag, shown on `rd_addr_flag`. The parity tag stays clear.
- R6: A low stop bit sets the framing tag. After a low stop bit, no new start is accepted until the line has been high on a tick.
- R7: A frame that is entirely low (data, any parity bit and stop) loads exactly one entry: data 0, break tag set, framing and parity tags clear.
- R8: The queue holds 3 characters in arrival order, and a `rd_pop` pulse removes the head. Status bit 0 means not empty, bit 1 means full, and bits 3:2 read 0.
- R9: A character that finishes while the queue is full is dropped and the stored entries stay as they were. This sets status bit 4 (overrun), which stays set until an error reset or a receiver reset.
- R10: With `cfg_block_err` = 0, status bits 7:5 show {break, framing, parity} of the head entry. They move to the next entry on a pop and read 0 when the queue is empty.
- R11: With `cfg_block_err` = 1, status bits 7:5 are the OR of the tags of every character completed since the last error reset or receiver reset. Pops do not clear them.
- R12: `rx_irq` follows status bit 0 when `cfg_irq_full` = 0 and status bit 1 when `cfg_irq_full` = 1.
- R13: `cmd_op` takes effect on a `cmd_valid` cycle: 00 enables, 01 disables, 10 is receiver reset and 11 is error reset. After `rst` the receiver is disabled and ignores the line. Receiver reset empties the queue, clears the overrun and accumulated flags, and disables the receiver. Error reset clears the overrun flag, the accumulated flags and the tags of stored entries, and keeps their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R13) |
| cfg_bits | input | 2 | Character length select |
| cfg_par_mode | input | 2 | Parity mode select |
| cfg_par_odd | input | 1 | Odd parity / forced parity value |
| cfg_block_err | input | 1 | 1 = accumulated error reporting |
| cfg_irq_full | input | 1 | 1 = interrupt on full, 0 = on not empty |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character data |
| rd_addr_flag | output | 1 | Head character address flag |
| rx_status | output | 8 | Status byte |
| rx_irq | output | 1 | Receiver interrupt request |

## Verification
A wrong tick count or bit index in the sampler shows up on `rd_data` for the very first character received. It also appears as a spurious framing tag about one bit time after the stop bit should have been taken. A queue pointer or occupancy error shows on the next pop as a character out of order, or as a wrong full or not-empty bit on the status byte in the same cycle. A wrong accumulated error flag stays hidden while per-character reporting is selected. It shows only once block mode is selected, and then only after pops that would otherwise have cleared the head tags. For that reason the bench checks it there.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PAR_CHECK = 2'b00,
        PAR_FORCE = 2'b01,
        PAR_NONE  = 2'b10,
        PAR_MDROP = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        OP_ENABLE    = 2'b00,
        OP_DISABLE   = 2'b01,
        OP_RX_RESET  = 2'b10,
        OP_ERR_RESET = 2'b11
    } rx_cmd_e;

    typedef struct packed {
        logic              addr_flag;
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // index of the final data bit: 5 bits -> 4 ... 8 bits -> 7
    function automatic logic [2:0] last_bit_idx(input logic [1:0] sel);
        return {1'b1, sel};
    endfunction

    function automatic logic parity_err(input logic [1:0] mode, input logic odd,
                                        input logic [DATA_W-1:0] d, input logic pb);
        case (mode)
            PAR_CHECK: return ((^d) ^ pb) != odd;
            PAR_FORCE: return pb != odd;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       en,
    input  logic       flush,
    input  logic [1:0] bits_sel,
    input  logic [1:0] par_mode,
    input  logic       par_odd,
    output logic       ch_vld,
    output rx_entry_t  ch
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_e;

    st_e               st;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    rx_entry_t         frame;

    // entry built from the bits gathered so far plus the stop sample on rxd
    always_comb begin
        frame.brk       = (shreg == '0) && !pbit && !rxd;
        frame.ferr      = !rxd && !frame.brk;
        frame.perr      = !frame.brk && parity_err(par_mode, par_odd, shreg, pbit);
        frame.addr_flag = (par_mode == PAR_MDROP) && pbit;
        frame.data      = shreg;
    end

    always_ff @(posedge clk) begin
        ch_vld <= 1'b0;
        if (rst || flush || !en) begin
            st <= S_IDLE;
            cnt <= '0;
            if (rst) begin
                bidx  <= '0;
                shreg <= '0;
                pbit  <= 1'b0;
                ch    <= '0;
            end
        end else if (tick) begin
            unique case (st)
                S_IDLE: if (!rxd) begin
                    st  <= S_START;
                    cnt <= '0;
                end
                S_START: if (cnt == MID) begin
                    cnt <= '0;
                    if (!rxd) begin
                        st    <= S_DATA;
                        bidx  <= '0;
                        shreg <= '0;
                        pbit  <= 1'b0;
                    end else begin
                        st <= S_IDLE;
                    end
                end else cnt <= cnt + 1'b1;
                S_DATA: if (cnt == LAST) begin
                    cnt         <= '0;
                    shreg[bidx] <= rxd;
                    if (bidx == last_bit_idx(bits_sel))
                        st <= (par_mode == PAR_NONE) ? S_STOP : S_PAR;
                    else
                        bidx <= bidx + 1'b1;
                end else cnt <= cnt + 1'b1;
                S_PAR: if (cnt == LAST) begin
                    cnt  <= '0;
                    pbit <= rxd;
                    st   <= S_STOP;
                end else cnt <= cnt + 1'b1;
                S_STOP: if (cnt == LAST) begin
                    cnt    <= '0;
                    ch_vld <= 1'b1;
                    ch     <= frame;
                    st     <= rxd ? S_IDLE : S_HOLD;
                end else cnt <= cnt + 1'b1;
                S_HOLD: if (rxd) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5: multidrop frames never carry a parity error
    a_r5_mdrop_no_perr: assert property (@(posedge clk) disable iff (rst)
        ch_vld && ($past(par_mode) == PAR_MDROP) |-> !ch.perr);

    // R7: a break entry carries data 0 and only the break tag
    a_r7_break_clean: assert property (@(posedge clk) disable iff (rst)
        ch_vld && ch.brk |-> !ch.ferr && !ch.perr && (ch.data == '0));

endmodule

// File: rtl/srx_tag_fifo.sv
module srx_tag_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      tag_clear,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] count;
    logic             do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovf     = push && full && !do_pop;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end
        end else begin
            if (tag_clear) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i].brk  <= 1'b0;
                    mem[i].ferr <= 1'b0;
                    mem[i].perr <= 1'b0;
                end
            end
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R9: a dropped character leaves the occupancy untouched
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop && !flush |=> $stable(count));

    // R8: a pop with no push removes exactly one entry
    a_r8_pop_one: assert property (@(posedge clk) disable iff (rst)
        pop && !empty && !push && !flush |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_all,
    input  logic       clear_err,
    input  logic       block_mode,
    input  logic       irq_full,
    input  logic       ch_vld,
    input  logic [2:0] ch_tags,
    input  logic [2:0] head_tags,
    input  logic       ovf,
    input  logic       empty,
    input  logic       full,
    output logic [7:0] status,
    output logic       irq
);
    logic [2:0] stk;
    logic       ovr;
    logic [2:0] tags;

    always_ff @(posedge clk) begin
        if (rst || clear_all || clear_err) begin
            stk <= '0;
            ovr <= 1'b0;
        end else begin
            if (ch_vld) stk <= stk | ch_tags;
            if (ovf)    ovr <= 1'b1;
        end
    end

    assign tags   = block_mode ? stk : (empty ? 3'b000 : head_tags);
    assign status = {tags, ovr, 2'b00, full, !empty};
    assign irq    = irq_full ? full : !empty;

    // R11: accumulated flags hold until one of the two clearing commands
    a_r11_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (stk != '0) && !clear_all && !clear_err |=> (stk & $past(stk)) == $past(stk));

    // R9: a dropped character raises overrun on the next cycle
    a_r9_ovr_sets: assert property (@(posedge clk) disable iff (rst)
        ovf && !clear_all && !clear_err |=> status[4]);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [1:0] cfg_bits,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_par_odd,
    input  logic       cfg_block_err,
    input  logic       cfg_irq_full,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_addr_flag,
    output logic [7:0] rx_status,
    output logic       rx_irq
);
    logic      rx_en, flush, err_clr;
    logic      ch_vld, q_empty, q_full, q_ovf;
    rx_entry_t ch, head;

    assign flush   = cmd_valid && (cmd_op == OP_RX_RESET);
    assign err_clr = cmd_valid && (cmd_op == OP_ERR_RESET);

    always_ff @(posedge clk) begin
        if (rst) rx_en <= 1'b0;
        else if (cmd_valid) begin
            case (cmd_op)
                OP_ENABLE:   rx_en <= 1'b1;
                OP_DISABLE:  rx_en <= 1'b0;
                OP_RX_RESET: rx_en <= 1'b0;
                default:     rx_en <= rx_en;
            endcase
        end
    end

    srx_sampler #(.OVS(OVS)) u_sampler (
        .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd), .en(rx_en), .flush(flush),
        .bits_sel(cfg_bits), .par_mode(cfg_par_mode), .par_odd(cfg_par_odd),
        .ch_vld(ch_vld), .ch(ch)
    );

    srx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush), .tag_clear(err_clr),
        .push(ch_vld), .din(ch), .pop(rd_pop),
        .head(head), .empty(q_empty), .full(q_full), .ovf(q_ovf)
    );

    srx_status u_status (
        .clk(clk), .rst(rst), .clear_all(flush), .clear_err(err_clr),
        .block_mode(cfg_block_err), .irq_full(cfg_irq_full),
        .ch_vld(ch_vld), .ch_tags({ch.brk, ch.ferr, ch.perr}),
        .head_tags({head.brk, head.ferr, head.perr}),
        .ovf(q_ovf), .empty(q_empty), .full(q_full),
        .status(rx_status), .irq(rx_irq)
    );

    assign rd_data      = head.data;
    assign rd_addr_flag = head.addr_flag;

    // R13: receiver reset leaves an empty, quiet status one cycle later
    a_r13_rx_reset_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rx_status == 8'h00) && !rx_irq);

endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    logic       clk = 1'b0, rst = 1'b1, tick16 = 1'b0, rxd = 1'b1;
    logic       cmd_valid = 1'b0, rd_pop = 1'b0;
    logic [1:0] cmd_op = 2'b00, cfg_bits = 2'b11, cfg_par_mode = 2'b10;
    logic       cfg_par_odd = 1'b0, cfg_block_err = 1'b0, cfg_irq_full = 1'b0;
    logic [7:0] rd_data, rx_status;
    logic       rd_addr_flag, rx_irq;

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cfg_bits(cfg_bits),
        .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
        .cfg_block_err(cfg_block_err), .cfg_irq_full(cfg_irq_full),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_addr_flag(rd_addr_flag),
        .rx_status(rx_status), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    int unsigned div = 0;
    always @(negedge clk) begin
        div    <= (div == 3) ? 0 : div + 1;
        tick16 <= (div == 3);
    end

    int nchk = 0, nfail = 0;
    // model entry: [11] addr flag, [10] break, [9] framing, [8] parity, [7:0] data
    logic [11:0] mq[$];
    logic        m_en = 1'b0, m_ovr = 1'b0;
    logic [2:0]  m_stk = 3'b000;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [2:0] tags;
        tags = cfg_block_err ? m_stk : ((mq.size() == 0) ? 3'b000 : mq[0][10:8]);
        return {tags, m_ovr, 2'b00, mq.size() == 3, mq.size() != 0};
    endfunction

    function automatic logic exp_irq();
        return cfg_irq_full ? (mq.size() == 3) : (mq.size() != 0);
    endfunction

    task automatic check_status(input string req);
        chk(rx_status == exp_status(), req, "status", rx_status, exp_status());
        chk(rx_irq == exp_irq(), req, "irq", rx_irq, exp_irq());
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        wait_clk(64);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic ad, input logic bad_par, input logic bad_stop);
        int nb;
        logic [7:0] dm;
        logic pb, brk, fe, pe, adf;
        nb = 5 + int'(cfg_bits);
        dm = d & 8'((9'h1 << nb) - 1);
        case (cfg_par_mode)
            2'b00:   pb = (^dm) ^ cfg_par_odd ^ bad_par;
            2'b01:   pb = cfg_par_odd ^ bad_par;
            2'b11:   pb = ad;
            default: pb = 1'b0;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(dm[i]);
        if (cfg_par_mode != 2'b10) send_bit(pb);
        send_bit(!bad_stop);
        rxd = 1'b1;
        wait_clk(64);
        brk = (dm == 8'h00) && !pb && bad_stop;
        fe  = bad_stop && !brk;
        pe  = !brk && bad_par && (cfg_par_mode[1] == 1'b0);
        adf = (cfg_par_mode == 2'b11) && pb;
        if (m_en) begin
            m_stk = m_stk | {brk, fe, pe};
            if (mq.size() == 3) m_ovr = 1'b1;
            else mq.push_back({adf, brk, fe, pe, dm});
        end
    endtask

    task automatic do_pop(input string req);
        if (mq.size() > 0) begin
            chk(rd_data == mq[0][7:0], req, "data", rd_data, mq[0][7:0]);
            chk(rd_addr_flag == mq[0][11], req, "addr flag", rd_addr_flag, mq[0][11]);
        end
        rd_pop = 1'b1;
        wait_clk(1);
        rd_pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        wait_clk(1);
        check_status(req);
    endtask

    task automatic do_cmd(input logic [1:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        wait_clk(1);
        cmd_valid = 1'b0;
        case (op)
            2'b00: m_en = 1'b1;
            2'b01: m_en = 1'b0;
            2'b10: begin mq.delete(); m_stk = 3'b000; m_ovr = 1'b0; m_en = 1'b0; end
            default: begin
                m_stk = 3'b000;
                m_ovr = 1'b0;
                foreach (mq[i]) mq[i][10:8] = 3'b000;
            end
        endcase
        wait_clk(1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_2A17));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check_status("R8");                        // reset: empty, no irq

        // R13: disabled after reset, line ignored
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        check_status("R13");
        do_cmd(2'b00);

        // R2: short low glitch loads nothing
        rxd = 1'b0; wait_clk(12); rxd = 1'b1; wait_clk(128);
        check_status("R2");

        // R1: every character length, no parity
        for (int b = 0; b < 4; b++) begin
            cfg_bits = 2'(b);
            send_frame(8'hA5 ^ 8'(b * 37), 1'b0, 1'b0, 1'b0);
            check_status("R1");
            do_pop("R1");
        end

        // R3: checked parity, even and odd, good and bad
        cfg_bits = 2'b11; cfg_par_mode = 2'b00;
        for (int k = 0; k < 4; k++) begin
            cfg_par_odd = k[0];
            send_frame(8'h6C + 8'(k), 1'b0, k[1], 1'b0);
            check_status("R3");
            do_pop("R3");
        end

        // R4: forced parity value
        cfg_par_mode = 2'b01;
        for (int k = 0; k < 4; k++) begin
            cfg_par_odd = k[0];
            send_frame(8'h31, 1'b0, k[1], 1'b0);
            check_status("R4");
            do_pop("R4");
        end

        // R5: multidrop address flag, never a parity tag
        cfg_par_mode = 2'b11;
        send_frame(8'h42, 1'b1, 1'b0, 1'b0);
        check_status("R5");
        do_pop("R5");
        send_frame(8'h43, 1'b0, 1'b0, 1'b0);
        do_pop("R5");

        // R6: low stop bit gives framing tag
        cfg_par_mode = 2'b10;
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        check_status("R6");
        do_pop("R6");

        // R7: break loads one zero entry with break tag
        send_frame(8'h00, 1'b0, 1'b0, 1'b1);
        check_status("R7");
        do_pop("R7");
        check_status("R7");

        // R12, R8, R9: fill, full, overrun
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        check_status("R12");
        cfg_irq_full = 1'b1;
        wait_clk(1);
        check_status("R12");
        send_frame(8'h22, 1'b0, 1'b0, 1'b0);
        send_frame(8'h33, 1'b0, 1'b0, 1'b0);
        check_status("R12");
        send_frame(8'h44, 1'b0, 1'b0, 1'b0);
        check_status("R9");
        do_pop("R8");
        do_pop("R8");
        do_pop("R8");
        check_status("R9");                        // overrun still set
        do_cmd(2'b11);
        check_status("R9");
        cfg_irq_full = 1'b0;

        // R10: head tags follow pops
        cfg_par_mode = 2'b00; cfg_par_odd = 1'b0;
        send_frame(8'h15, 1'b0, 1'b1, 1'b0);
        send_frame(8'h16, 1'b0, 1'b0, 1'b0);
        send_frame(8'h17, 1'b0, 1'b0, 1'b1);
        check_status("R10");
        do_pop("R10");
        do_pop("R10");
        do_pop("R10");

        // R11: accumulated reporting
        do_cmd(2'b11);
        cfg_block_err = 1'b1;
        send_frame(8'h71, 1'b0, 1'b1, 1'b0);
        send_frame(8'h72, 1'b0, 1'b0, 1'b0);
        do_pop("R11");
        do_pop("R11");
        check_status("R11");
        do_cmd(2'b11);
        check_status("R11");
        cfg_block_err = 1'b0;

        // R13: error reset clears stored tags, keeps data
        send_frame(8'h5E, 1'b0, 1'b1, 1'b0);
        check_status("R13");
        do_cmd(2'b11);
        check_status("R13");
        do_pop("R13");

        // R13: receiver reset flushes and disables
        send_frame(8'h01, 1'b0, 1'b0, 1'b0);
        send_frame(8'h02, 1'b0, 1'b1, 1'b0);
        do_cmd(2'b10);
        check_status("R13");
        send_frame(8'h03, 1'b0, 1'b0, 1'b0);
        check_status("R13");
        do_cmd(2'b00);
        do_cmd(2'b01);
        send_frame(8'h04, 1'b0, 1'b0, 1'b0);
        check_status("R13");
        do_cmd(2'b00);

        // random mix over lengths, parity modes and errors (R1, R3, R4, R5, R6, R7, R10)
        do_cmd(2'b11);
        for (int it = 0; it < 40; it++) begin
            cfg_bits     = 2'($urandom_range(0, 3));
            cfg_par_mode = 2'($urandom_range(0, 3));
            cfg_par_odd  = 1'($urandom_range(0, 1));
            send_frame(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                       ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0));
            check_status("R10");
            if ($urandom_range(0, 2) != 0 || mq.size() == 3) begin
                while (mq.size() > 0) do_pop("R1");
            end
        end
        while (mq.size() > 0) do_pop("R8");
        finish_run();
    end
endmodule